// File: doc/BRIEF.md
# Dual Serial ADC Command Front End

This block sits between an 8-bit host register bus and two 8-channel serial analog-to-digital converters whose links shift in both directions at once. Each converter has its own small register set: a command register, a two-byte result and a status register. The register sets are stacked four bytes apart. When the host writes a command byte, the block runs one full-duplex transfer on that converter's link. The command byte goes out during the first eight serial clocks. All sixteen clocks bring back a result, and when the frame is over the block raises data-ready.

The converters work as a pipeline. What comes back during a transfer is the conversion set up by the command before it. Host software must therefore throw away the first sample after it changes the channel, range or input mode. Software chooses a channel by addressing a unit. Channels 0 to 7 are handled by the register set at base 0. Channels 8 to 15 are handled by the set at base 4, with 8 subtracted from the channel number.

Top module: `dual_adc_frontend`

## Requirements
- R1: Address bit 2 and the bits above it select the converter unit. Address bits 1:0 select a register within that unit: 0 is result low byte, 1 is result high byte, 2 is command and 3 is status. Reads are combinational from `bus_addr`.
- R2: A command write to an idle unit starts one transfer carrying the written byte unchanged. Reading offset 2 returns the last accepted command. The byte layout is bit 7 single-ended, bit 6 odd channel, bits 5:4 channel/2 and bits 3:2 range code. Channel 13 single-ended at range 3 is therefore byte 0xEC written to unit 1.
- R3: Each transfer holds chip select low for exactly 16 rising edges of the serial clock, and the serial clock idles low. MOSI carries the command MSB first on the first 8 bits and 0 on the last 8. MOSI changes only on falling edges and is valid from the moment chip select falls.
- R4: Each half period of the serial clock lasts CLK_DIV system clocks. Status data-ready becomes visible 32*CLK_DIV+1 clock edges after the edge that accepts the command write.
- R5: The 16 MISO bits are sampled MSB first on rising serial-clock edges. The low byte is readable at offset 0 and the high byte at offset 1. Since the converter lags, the value returned belongs to the previous command. The first transfer after reset returns the converter's response to an all-zero command.
- R6: An accepted command write clears data-ready (status bit 7) on the next edge. Data-ready sets only after all 16 bits are captured, the serial clock is back low and chip select is released.
- R7: A command write while a transfer is running is ignored. That includes the cycle of completion. An ignored write starts no frame and leaves the readback and the result unchanged. It sets the sticky overrun flag, status bit 5, which is cleared by writing 1 to status bit 5.
- R8: Status bit 0 is a writable interrupt enable. Status bit 4 (pending) sets when a transfer completes while the enable is 1, and is cleared by writing 1 to bit 4. `irq` is the OR of the pending flags of all units. With the enable at 0, completion sets nothing.
- R9: The units are independent. A write to one unit never drives chip select of another unit low and never changes another unit's status or result.
- R10: After reset, every status and result byte is 0, every chip select is high, every serial clock is low and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (3) | Register address: unit number above bit 1, register offset in bits 1:0 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Any unit has an interrupt pending |
| adc_sclk | output | NUM_UNITS | Serial clock per converter, idles low |
| adc_cs_n | output | NUM_UNITS | Active-low chip select per converter |
| adc_mosi | output | NUM_UNITS | Command data to each converter |
| adc_miso | input | NUM_UNITS | Result data from each converter |

## Verification
The assertions assume that MISO only needs to be stable at rising serial-clock edges, and that the host issues single-cycle write strobes. They also assume that status writes never collide with the completion cycle in a way that matters for the overrun or pending checks. The bench's behavioural converters change MISO only on falling edges and when chip select falls. The bench drives every bus write at a falling system-clock edge for exactly one cycle, and it starts the deliberate collision one cycle after an accepted command, well inside the frame.

// File: rtl/adc_fe_pkg.sv
`timescale 1ns/1ps
package adc_fe_pkg;
  // register offsets inside one unit (host visible)
  localparam int REG_LSB  = 0;
  localparam int REG_MSB  = 1;
  localparam int REG_CMD  = 2;
  localparam int REG_STAT = 3;

  // status bit positions
  localparam int ST_READY = 7;
  localparam int ST_OVR   = 5;
  localparam int ST_PEND  = 4;
  localparam int ST_IEN   = 0;

  typedef struct packed {
    logic ready;
    logic ovr;
    logic pend;
    logic ien;
  } unit_flags_t;

  function automatic logic [7:0] status_byte(unit_flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[ST_READY] = f.ready;
    b[ST_OVR]   = f.ovr;
    b[ST_PEND]  = f.pend;
    b[ST_IEN]   = f.ien;
    return b;
  endfunction

  // system clocks from command accept to the final falling serial edge
  function automatic int unsigned frame_cycles(int unsigned frame_bits, int unsigned div);
    return 2 * frame_bits * div;
  endfunction
endpackage

// File: rtl/adc_serial_engine.sv
`timescale 1ns/1ps
module adc_serial_engine #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 16,
  parameter int CMD_BITS   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CMD_BITS-1:0]   cmd,
  output logic                  busy,
  output logic                  done,
  output logic [FRAME_BITS-1:0] result,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int PAD_W = FRAME_BITS - CMD_BITS;

  logic                  active;
  logic                  done_q;
  logic                  sclk_q;
  logic [DIV_W-1:0]      div_cnt;
  logic [BIT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] sh_out;
  logic [FRAME_BITS-1:0] sh_in;

  // named internal events
  logic edge_tick, rise_ev, fall_ev, last_fall, launch;
  assign edge_tick = active && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign rise_ev   = edge_tick && !sclk_q;
  assign fall_ev   = edge_tick && sclk_q;
  assign last_fall = fall_ev && (bit_cnt == BIT_W'(FRAME_BITS - 1));
  assign launch    = start && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh_out  <= '0;
      sh_in   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        active  <= 1'b1;
        sclk_q  <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
        sh_out  <= {cmd, {PAD_W{1'b0}}};
      end else if (active) begin
        if (edge_tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
        if (rise_ev) begin
          sclk_q <= 1'b1;
          sh_in  <= {sh_in[FRAME_BITS-2:0], miso};
        end
        if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_fall) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh_out  <= {sh_out[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy   = active || done_q;
  assign done   = done_q;
  assign result = sh_in;
  assign sclk   = sclk_q;
  assign cs_n   = !active;
  assign mosi   = active && sh_out[FRAME_BITS-1];

  // independent count of serial rising edges inside one frame
  logic [BIT_W:0] rise_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rise_seen <= '0;
    else if (launch)  rise_seen <= '0;
    else if (rise_ev) rise_seen <= rise_seen + 1'b1;
  end

  a_r3_sixteen_rises: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_seen == (BIT_W+1)'(FRAME_BITS)));
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && cs_n));
endmodule

// File: rtl/adc_unit_regs.sv
`timescale 1ns/1ps
module adc_unit_regs
  import adc_fe_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [1:0]            ofs,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  start,
  output logic [7:0]            cmd_out,
  input  logic                  busy,
  input  logic                  done,
  input  logic [FRAME_BITS-1:0] result,
  output logic                  irq
);
  unit_flags_t           flags;
  logic [7:0]            cmd_q;
  logic [FRAME_BITS-1:0] res_q;

  // named bus events
  logic cmd_wr, stat_wr, accept, collide;
  assign cmd_wr  = wr && (ofs == 2'(REG_CMD));
  assign stat_wr = wr && (ofs == 2'(REG_STAT));
  assign accept  = cmd_wr && !busy;
  assign collide = cmd_wr && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cmd_q <= '0;
      res_q <= '0;
    end else begin
      if (stat_wr) begin
        flags.ien <= wdata[ST_IEN];
        if (wdata[ST_PEND]) flags.pend <= 1'b0;
        if (wdata[ST_OVR])  flags.ovr  <= 1'b0;
      end
      if (collide) flags.ovr <= 1'b1;
      if (accept) begin
        cmd_q       <= wdata;
        flags.ready <= 1'b0;
      end else if (done) begin
        flags.ready <= 1'b1;
        res_q       <= result;
        if (flags.ien) flags.pend <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ofs)
      2'(REG_LSB): rdata = res_q[7:0];
      2'(REG_MSB): rdata = res_q[FRAME_BITS-1:8];
      2'(REG_CMD): rdata = cmd_q;
      default:     rdata = status_byte(flags);
    endcase
  end

  assign start   = accept;
  assign cmd_out = wdata;
  assign irq     = flags.pend;

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> flags.ovr);
  a_r7_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> $stable(cmd_q));
  a_r6_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !flags.ready);
  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flags.ready);
  a_r8_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.pend) |-> $past(flags.ien));
endmodule

// File: rtl/dual_adc_frontend.sv
`timescale 1ns/1ps
module dual_adc_frontend #(
  parameter int NUM_UNITS = 2,
  parameter int CLK_DIV   = 4,
  parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  parameter int ADDR_W    = UNIT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 irq,
  output logic [NUM_UNITS-1:0] adc_sclk,
  output logic [NUM_UNITS-1:0] adc_cs_n,
  output logic [NUM_UNITS-1:0] adc_mosi,
  input  logic [NUM_UNITS-1:0] adc_miso
);
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 8;

  logic [UNIT_W-1:0]    unit_sel;
  logic [1:0]           reg_ofs;
  logic [NUM_UNITS-1:0] wr_u;
  logic [NUM_UNITS-1:0] irq_u;
  logic [7:0]           rd_u [NUM_UNITS];

  assign unit_sel = bus_addr[ADDR_W-1:2];
  assign reg_ofs  = bus_addr[1:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic                  start, busy, done;
    logic [CMD_BITS-1:0]   cmd;
    logic [FRAME_BITS-1:0] result;

    assign wr_u[u] = bus_wr && (unit_sel == UNIT_W'(u));

    adc_unit_regs #(.FRAME_BITS(FRAME_BITS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_u[u]),
      .ofs     (reg_ofs),
      .wdata   (bus_wdata),
      .rdata   (rd_u[u]),
      .start   (start),
      .cmd_out (cmd),
      .busy    (busy),
      .done    (done),
      .result  (result),
      .irq     (irq_u[u])
    );

    adc_serial_engine #(
      .CLK_DIV   (CLK_DIV),
      .FRAME_BITS(FRAME_BITS),
      .CMD_BITS  (CMD_BITS)
    ) u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cmd    (cmd),
      .busy   (busy),
      .done   (done),
      .result (result),
      .sclk   (adc_sclk[u]),
      .cs_n   (adc_cs_n[u]),
      .mosi   (adc_mosi[u]),
      .miso   (adc_miso[u])
    );

    a_r9_cs_own_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n[u]) |-> $past(wr_u[u]));
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int u = 0; u < NUM_UNITS; u++)
      if (unit_sel == UNIT_W'(u)) bus_rdata = rd_u[u];
  end

  assign irq = |irq_u;
endmodule

// File: tb/sim_dual_adc_frontend.sv
`timescale 1ns/1ps
module sim_adc_model #(
  parameter logic [7:0] SALT = 8'h00
) (
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  logic [7:0]  prev_cmd = 8'h00;
  logic [15:0] out_sh   = 16'h0000;
  logic [15:0] in_sh    = 16'h0000;
  logic [7:0]  got_cmd  = 8'h00;
  logic [7:0]  got_tail = 8'h00;
  logic        armed    = 1'b0;
  int          rises    = 0;
  int          last_rises = 0;
  int          xfers    = 0;

  initial miso = 1'b0;

  always @(negedge cs_n) begin
    armed  = 1'b1;
    out_sh = {prev_cmd ^ SALT, ~prev_cmd};
    miso   = out_sh[15];
    rises  = 0;
  end
  always @(negedge sclk) if (cs_n == 1'b0) begin
    out_sh = {out_sh[14:0], 1'b0};
    miso   = out_sh[15];
  end
  always @(posedge sclk) if (cs_n == 1'b0) begin
    in_sh = {in_sh[14:0], mosi};
    rises = rises + 1;
  end
  always @(posedge cs_n) if (armed) begin
    armed      = 1'b0;
    got_cmd    = in_sh[15:8];
    got_tail   = in_sh[7:0];
    prev_cmd   = got_cmd;
    last_rises = rises;
    xfers      = xfers + 1;
  end
endmodule

module sim_dual_adc_frontend;
  localparam int CLK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [1:0] adc_sclk, adc_cs_n, adc_mosi, adc_miso;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dual_adc_frontend #(.NUM_UNITS(2), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_mosi(adc_mosi),
    .adc_miso(adc_miso)
  );

  sim_adc_model #(.SALT(8'h3C)) m0 (.cs_n(adc_cs_n[0]), .sclk(adc_sclk[0]),
                                    .mosi(adc_mosi[0]), .miso(adc_miso[0]));
  sim_adc_model #(.SALT(8'h96)) m1 (.cs_n(adc_cs_n[1]), .sclk(adc_sclk[1]),
                                    .mosi(adc_mosi[1]), .miso(adc_miso[1]));

  // scoreboard state
  logic [15:0] exp_q [2][$];
  logic [7:0]  last_cmd [2] = '{8'h00, 8'h00};

  function automatic logic [15:0] exp_sample(int u, logic [7:0] c);
    logic [7:0] hi;
    hi = c ^ ((u == 1) ? 8'h96 : 8'h3C);
    return {hi, ~c};
  endfunction

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic issue(int u, logic [7:0] c);
    exp_q[u].push_back(exp_sample(u, last_cmd[u]));
    last_cmd[u] = c;
    bus_write(3'(u * 4 + 2), c);
  endtask

  task automatic wait_ready(int u);
    logic [7:0] st;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      peek(3'(u * 4 + 3), st);
      if (st[7]) return;
    end
    chk("R6", "ready timeout", 16'h0, 16'h1);
  endtask

  task automatic collect(int u, string req);
    logic [7:0]  lo, hi;
    logic [15:0] exp;
    wait_ready(u);
    peek(3'(u * 4 + 0), lo);
    peek(3'(u * 4 + 1), hi);
    exp = (exp_q[u].size() > 0) ? exp_q[u].pop_front() : 16'hxxxx;
    chk(req, "result", {hi, lo}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] st, v;
    int cnt, x0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    peek(3'd3, st); chk("R10", "u0 status", {8'h0, st}, 16'h0000);
    peek(3'd7, st); chk("R10", "u1 status", {8'h0, st}, 16'h0000);
    peek(3'd0, st); chk("R10", "u0 lsb", {8'h0, st}, 16'h0000);
    chk("R10", "cs_n", {14'h0, adc_cs_n}, 16'h0003);
    chk("R10", "sclk", {14'h0, adc_sclk}, 16'h0000);
    chk("R10", "irq", {15'h0, irq}, 16'h0000);

    // R4 frame timing
    issue(0, 8'hA8);
    cnt = 0;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk); peek(3'd3, st);
    end while (!st[7] && cnt < 1000);
    chk("R4", "accept-to-ready edges", 16'(cnt), 16'(32 * CLK_DIV + 1));
    // R5 first result after reset is the response to an all-zero command
    collect(0, "R5");
    chk("R3", "mosi command", {8'h0, m0.got_cmd}, 16'h00A8);
    chk("R3", "mosi tail zero", {8'h0, m0.got_tail}, 16'h0000);
    chk("R3", "rising edges", 16'(m0.last_rises), 16'd16);

    // R5 pipelined results over several patterns
    foreach (last_cmd[i]) begin end
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? 8'h5C : (k == 1) ? 8'hFF : (k == 2) ? 8'h00 : 8'h93;
      issue(0, v);
      if (k == 0) begin
        peek(3'd3, st);
        chk("R6", "ready cleared by command", {15'h0, st[7]}, 16'h0);
      end
      collect(0, "R5");
      chk("R3", "mosi command", {8'h0, m0.got_cmd}, {8'h0, v});
    end
    peek(3'd2, st); chk("R2", "cmd readback", {8'h0, st}, 16'h0093);

    // R7 collision is ignored and flagged
    x0 = m0.xfers;
    issue(0, 8'h4C);
    bus_write(3'd2, 8'hD0);
    peek(3'd2, st); chk("R7", "cmd readback unchanged", {8'h0, st}, 16'h004C);
    collect(0, "R7");
    repeat (4 * CLK_DIV) @(negedge clk);
    chk("R7", "frames started", 16'(m0.xfers - x0), 16'd1);
    chk("R7", "converter saw first cmd", {8'h0, m0.got_cmd}, 16'h004C);
    peek(3'd3, st); chk("R7", "status overrun", {8'h0, st}, 16'h00A0);
    bus_write(3'd3, 8'h20);
    peek(3'd3, st); chk("R7", "overrun cleared", {8'h0, st}, 16'h0080);

    // R8 interrupt enable / pending
    bus_write(3'd3, 8'h01);
    issue(0, 8'h18);
    collect(0, "R8");
    chk("R8", "irq raised", {15'h0, irq}, 16'h1);
    peek(3'd3, st); chk("R8", "status pend", {8'h0, st}, 16'h0091);
    bus_write(3'd3, 8'h11);
    chk("R8", "irq cleared", {15'h0, irq}, 16'h0);
    peek(3'd3, st); chk("R8", "status after w1c", {8'h0, st}, 16'h0081);
    bus_write(3'd3, 8'h00);
    issue(0, 8'h34);
    collect(0, "R8");
    chk("R8", "no irq when disabled", {15'h0, irq}, 16'h0);
    peek(3'd3, st); chk("R8", "status disabled", {8'h0, st}, 16'h0080);

    // R9 / R2 second unit: channel 13, single-ended, range 3 -> 0xEC
    x0 = m0.xfers;
    issue(1, 8'hEC);
    repeat (8) @(negedge clk);
    chk("R9", "u0 cs_n idle", {15'h0, adc_cs_n[0]}, 16'h1);
    peek(3'd3, st); chk("R9", "u0 status untouched", {8'h0, st}, 16'h0080);
    collect(1, "R9");
    chk("R2", "u1 converter got 0xEC", {8'h0, m1.got_cmd}, 16'h00EC);
    issue(1, 8'h24);
    collect(1, "R5");
    chk("R9", "u0 frames", 16'(m0.xfers - x0), 16'd0);

    // R1 address map
    peek(3'd6, st); chk("R1", "u1 cmd at 6", {8'h0, st}, 16'h0024);
    peek(3'd2, st); chk("R1", "u0 cmd at 2", {8'h0, st}, 16'h0034);
    peek(3'd4, st); chk("R1", "u1 lsb at 4", {8'h0, st}, {8'h0, ~8'hEC});
    peek(3'd5, st); chk("R1", "u1 msb at 5", {8'h0, st}, {8'h0, 8'hEC ^ 8'h96});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule